// File: doc/BRIEF.md
# Beam Permit Loop Slave Node

This block sits on a looped beam permit signal as one slave station. The loop is a pair of wires: a go path and a return path. While the node holds PASS, both paths are passed through. Once it decides VETO, both paths are broken, and every station downstream sees the permit withdrawn, so the next beam is inhibited.

The decision comes from a stream of data words delivered with a valid strobe and a corruption flag. A word flagged as corrupted is counted and dropped. It is not repaired and not analysed. Every clean word is compared with a programmable low bound and a programmable high bound. A single word outside that window is an interlock request. The request breaks the loop in the same cycle it is presented and latches VETO from the next clock edge. VETO remains until an explicit re-arm.

Words arrive in frames of a fixed length, by default 32 words per emulated pulse. The node tracks its position inside the frame and keeps saturating counts of dropped words and of interlock requests.

Top module: `permit_node`

## Requirements
- R1: After reset the node is in PASS (`pass_o`=1), both counters read 0, and `word_pos` reads 0.
- R2: A clean word (`rx_valid`=1, `rx_err`=0) is a request when its unsigned value is strictly below `thr_lo` or strictly above `thr_hi`. A value equal to either bound is not a request.
- R3: In the cycle a request word is presented, `go_out` and `ret_out` are both 0, without waiting for a clock edge or for the end of the frame.
- R4: The clock edge that samples a request word sets VETO (`pass_o`=0). VETO then holds on every later edge until a re-arm.
- R5: With `rearm`=1 and no request in the same cycle, the next edge returns the node to PASS. If a request is present in that cycle, the node is in VETO after the edge.
- R6: A word with `rx_err`=1 never causes VETO, whatever its data value.
- R7: `go_out` = `go_in` AND PASS AND no current request, and `ret_out` follows the same rule with `ret_in`.
- R8: `rej_cnt` counts words with `rx_valid`=1 and `rx_err`=1. `ilk_cnt` counts request words. Each counter is 16 bits wide and holds at 65535 once it reaches that value.
- R9: `word_pos` advances by one on every valid word, whether clean or corrupted. After position 31 it returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A data word is present this cycle |
| rx_data | input | 16 | Data word |
| rx_err | input | 1 | Word is flagged as corrupted |
| thr_lo | input | 16 | Low bound of the accepted window |
| thr_hi | input | 16 | High bound of the accepted window |
| rearm | input | 1 | Return from VETO to PASS |
| go_in | input | 1 | Upstream permit, go path |
| ret_in | input | 1 | Upstream permit, return path |
| go_out | output | 1 | Downstream permit, go path |
| ret_out | output | 1 | Downstream permit, return path |
| pass_o | output | 1 | 1 = PASS, 0 = VETO |
| word_pos | output | 5 | Position of the next word within its frame |
| rej_cnt | output | 16 | Count of dropped words, saturating |
| ilk_cnt | output | 16 | Count of request words, saturating |

## Verification
Random words are drawn across the whole 16-bit range, so clean in-window words, clean out-of-window words and corrupted out-of-window words all occur. The random stream also toggles the upstream permits and issues sparse re-arms. Comparing the results separates a correct window test from one that ignores the corruption flag or lets the loop follow only one path. Directed words sit exactly on each bound and one step outside it, which separates strict from inclusive comparison. A re-arm given in the same cycle as a request checks the priority of the request. A long run of corrupted words drives the drop counter into saturation, and 33 consecutive words check that the frame position wraps.

// File: rtl/permit_node_pkg.sv
package permit_node_pkg;
  typedef enum logic {
    ST_VETO = 1'b0,
    ST_PASS = 1'b1
  } permit_e;
endpackage

// File: rtl/word_screen.sv
module word_screen #(
  parameter int DATA_W = 16
) (
  input  logic              in_valid,
  input  logic              in_err,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] lim_lo,
  input  logic [DATA_W-1:0] lim_hi,
  output logic              word_ok,
  output logic              word_bad,
  output logic              req
);
  logic below, above;

  always_comb begin
    below    = in_data < lim_lo;
    above    = in_data > lim_hi;
    word_ok  = in_valid & ~in_err;
    word_bad = in_valid & in_err;
    req      = word_ok & (below | above);
  end
endmodule

// File: rtl/veto_latch.sv
module veto_latch
  import permit_node_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    rearm,
  output permit_e state_q
);
  permit_e state_d;
  logic    upd;

  always_comb begin
    upd     = req | rearm;
    state_d = state_q;
    if (req)        state_d = ST_VETO;
    else if (rearm) state_d = ST_PASS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= ST_PASS;
    else if (upd) state_q <= state_d;
  end

  AST_REQ_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> state_q == ST_VETO); // R4
  AST_VETO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VETO && !rearm) |=> state_q == ST_VETO); // R4
  AST_REARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !req) |=> state_q == ST_PASS); // R5
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic [CNT_W-1:0] cnt_d;
  logic             upd;

  always_comb begin
    upd   = inc && (cnt_q != TOP);
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  AST_SAT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == TOP |=> cnt_q == TOP); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/frame_tracker.sv
module frame_tracker #(
  parameter int FRAME_WORDS = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           step,
  output logic [$clog2(FRAME_WORDS)-1:0] pos_q
);
  localparam int IDX_W = $clog2(FRAME_WORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_WORDS - 1);
  logic [IDX_W-1:0] pos_d;

  always_comb begin
    pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (step) pos_q <= pos_d;
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST); // R9
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pos_q == LAST) |=> pos_q == '0); // R9
endmodule

// File: rtl/permit_node.sv
module permit_node
  import permit_node_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int FRAME_WORDS = 32,
  localparam int IDX_W      = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_err,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic              rearm,
  input  logic              go_in,
  input  logic              ret_in,
  output logic              go_out,
  output logic              ret_out,
  output logic              pass_o,
  output logic [IDX_W-1:0]  word_pos,
  output logic [CNT_W-1:0]  rej_cnt,
  output logic [CNT_W-1:0]  ilk_cnt
);
  logic    word_ok, word_bad, req;
  permit_e state_q;
  logic    closed;

  word_screen #(.DATA_W(DATA_W)) i_screen (
    .in_valid (rx_valid),
    .in_err   (rx_err),
    .in_data  (rx_data),
    .lim_lo   (thr_lo),
    .lim_hi   (thr_hi),
    .word_ok  (word_ok),
    .word_bad (word_bad),
    .req      (req)
  );

  veto_latch i_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .rearm   (rearm),
    .state_q (state_q)
  );

  sat_counter #(.CNT_W(CNT_W)) i_rej_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (word_bad),
    .cnt_q (rej_cnt)
  );

  sat_counter #(.CNT_W(CNT_W)) i_ilk_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (req),
    .cnt_q (ilk_cnt)
  );

  frame_tracker #(.FRAME_WORDS(FRAME_WORDS)) i_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (rx_valid),
    .pos_q (word_pos)
  );

  always_comb begin
    pass_o  = (state_q == ST_PASS);
    closed  = pass_o & ~req;
    go_out  = go_in  & closed;
    ret_out = ret_in & closed;
  end

  AST_LOOP_OPEN_IN_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_o |-> (!go_out && !ret_out)); // R7
  AST_BAD_WORD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err && pass_o && !rearm) |=> pass_o); // R6
  AST_LOOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o && !rx_valid) |-> (go_out == go_in && ret_out == ret_in)); // R7
endmodule

// File: tb/test_permit_node.sv
`timescale 1ns/1ps
module test_permit_node;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_err, rearm, go_in, ret_in;
  logic [15:0] rx_data, thr_lo, thr_hi;
  logic        go_out, ret_out, pass_o;
  logic [4:0]  word_pos;
  logic [15:0] rej_cnt, ilk_cnt;

  int checks = 0;
  int errors = 0;

  logic        e_pass;
  logic [4:0]  e_pos;
  logic [15:0] e_rej, e_ilk;

  always #4 clk = ~clk;

  permit_node i_permit_node (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .thr_lo(thr_lo), .thr_hi(thr_hi), .rearm(rearm),
    .go_in(go_in), .ret_in(ret_in), .go_out(go_out), .ret_out(ret_out),
    .pass_o(pass_o), .word_pos(word_pos), .rej_cnt(rej_cnt), .ilk_cnt(ilk_cnt)
  );

  function automatic logic is_req(logic v, logic e, logic [15:0] d,
                                  logic [15:0] lo, logic [15:0] hi);
    return v && !e && (d < lo || d > hi);
  endfunction

  function automatic logic [15:0] sat_inc(logic [15:0] c, logic inc);
    return (inc && c != 16'hFFFF) ? c + 16'd1 : c;
  endfunction

  task automatic chk(logic ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic v, logic [15:0] d, logic e, logic ra,
                      logic gi, logic ri, logic full);
    logic r, eg, er;
    @(negedge clk);
    rx_valid = v; rx_data = d; rx_err = e; rearm = ra; go_in = gi; ret_in = ri;
    #1;
    r  = is_req(v, e, d, thr_lo, thr_hi);
    eg = gi & e_pass & ~r;
    er = ri & e_pass & ~r;
    if (full || r) begin
      chk(go_out == eg, r ? "R3 go path" : "R7 go path", go_out, eg);
      chk(ret_out == er, r ? "R3 ret path" : "R7 ret path", ret_out, er);
    end
    @(posedge clk);
    if (r)       e_pass = 1'b0;
    else if (ra) e_pass = 1'b1;
    e_rej = sat_inc(e_rej, v & e);
    e_ilk = sat_inc(e_ilk, r);
    if (v) e_pos = e_pos + 5'd1;
    #1;
    if (full) begin
      chk(pass_o == e_pass, r ? "R4 veto latch" : (ra ? "R5 rearm" : "R6 R4 hold"),
          pass_o, e_pass);
      chk(rej_cnt == e_rej, "R8 rej_cnt", rej_cnt, e_rej);
      chk(ilk_cnt == e_ilk, "R8 ilk_cnt", ilk_cnt, e_ilk);
      chk(word_pos == e_pos, "R9 word_pos", word_pos, e_pos);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    process::self().srandom(32'd20240611);
    rst_n = 1'b0; rx_valid = 0; rx_data = 0; rx_err = 0; rearm = 0;
    go_in = 1; ret_in = 1; thr_lo = 16'h1000; thr_hi = 16'hF000;
    e_pass = 1; e_pos = 0; e_rej = 0; e_ilk = 0;
    #20;
    // R1 reset state
    chk(pass_o == 1'b1, "R1 pass after reset", pass_o, 1);
    chk(rej_cnt == 0 && ilk_cnt == 0, "R1 counters", rej_cnt + ilk_cnt, 0);
    chk(word_pos == 0, "R1 word_pos", word_pos, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 boundaries: equal to bounds accepted
    step(1, 16'h1000, 0, 0, 1, 1, 1);
    step(1, 16'hF000, 0, 0, 1, 1, 1);
    chk(pass_o == 1'b1, "R2 equal bounds not request", pass_o, 1);
    // R6 corrupted out-of-range words
    step(1, 16'h0000, 1, 0, 1, 1, 1);
    step(1, 16'hFFFF, 1, 0, 1, 1, 1);
    chk(pass_o == 1'b1, "R6 corrupted ignored", pass_o, 1);
    // R2 one below low bound
    step(1, 16'h0FFF, 0, 0, 1, 1, 1);
    chk(pass_o == 1'b0, "R2 below low trips", pass_o, 0);
    step(0, 16'h0, 0, 0, 1, 1, 1);
    step(0, 16'h0, 0, 1, 1, 1, 1);
    chk(pass_o == 1'b1, "R5 rearm to pass", pass_o, 1);
    // R2 one above high
    step(1, 16'hF001, 0, 0, 1, 1, 1);
    chk(pass_o == 1'b0, "R2 above high trips", pass_o, 0);
    // R5 rearm with simultaneous request stays VETO
    step(1, 16'hFFFF, 0, 1, 1, 1, 1);
    chk(pass_o == 1'b0, "R5 request beats rearm", pass_o, 0);
    step(0, 16'h0, 0, 1, 1, 1, 1);
    // R9 frame wrap
    for (int i = 0; i < 33; i++) step(1, 16'h8000, i[0], 0, 1, 0, 1);
    chk(word_pos == e_pos, "R9 wrap", word_pos, e_pos);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      if (i % 300 == 0) begin
        thr_lo = 16'($urandom_range(16'h0400, 16'h3000));
        thr_hi = 16'($urandom_range(16'hC000, 16'hFC00));
      end
      step(($urandom % 4) != 0, 16'($urandom), ($urandom % 6) == 0,
           ($urandom % 8) == 0, 1'($urandom), 1'($urandom), 1);
    end

    // R8 saturation of rej_cnt with corrupted words
    for (int i = 0; i < 65540; i++) step(1, 16'h0, 1, 0, 1, 1, 0);
    chk(rej_cnt == 16'hFFFF, "R8 rej_cnt saturates", rej_cnt, 16'hFFFF);
    chk(ilk_cnt == e_ilk, "R8 ilk_cnt unchanged", ilk_cnt, e_ilk);
    step(1, 16'h0, 1, 0, 1, 1, 1);
    finish_run();
  end
endmodule